// File: doc/BRIEF.md
# Infrared Carrier Mark/Space Modulator

This block drives an infrared transmit line from a stream of segment descriptors. Each descriptor gives a level and a length counted in whole carrier periods, stored as the count minus one. While a mark segment plays, the line carries a pulse-width-modulated carrier. While a space segment plays, the line stays low. Software converts durations into carrier counts, so no arithmetic on time is done here.

Two registers set the carrier. `cfg_period_m1` holds the carrier period in clock cycles minus one. `cfg_compare` is the phase at which the line turns high within each carrier period, so a compare of (period)×(1−duty) gives the wanted duty. Both are latched when a start is accepted. A start is refused when the period lies outside the range set by the parameters, which is derived from the permitted 10 kHz to 40 kHz carrier band, or when the compare value exceeds the period.

Two holding slots form a double buffer: one slot plays while the next is filled. The input follows valid/ready rules. An entry transfers on a rising clock edge where both `in_valid` and `in_ready` are high. The producer must hold an entry stable while `in_ready` is low, and `in_ready` does not depend on `in_valid`. Entries may be queued while idle, before the start.

When a transmission ends normally, a fixed low trailer plays before the block reports completion. When the stream runs dry, the block stops at once with an underrun flag.

Top module: `irtx_modulator`

## Requirements
- R1: A start is refused, and `busy` stays low, when `cfg_period_m1` is below MIN_PER_M1, above MAX_PER_M1, or `cfg_compare` is greater than `cfg_period_m1`+1.
- R2: After a start is accepted, `busy` rises and `tx_out` stays low for exactly one carrier period (`cfg_period_m1`+1 cycles) before the first entry plays.
- R3: In a mark segment (`in_level`=1), `tx_out` is high in exactly those cycles whose phase within the carrier period is at least `cfg_compare`. A compare of 0 gives a constant high, and a compare of period+1 gives a constant low. In a space segment (`in_level`=0), `tx_out` is low.
- R4: A segment lasts exactly (`in_reps_m1`+1) carrier periods. The line changes between segments only at a carrier period boundary.
- R5: `in_ready` is high when fewer than two entries are held, no entry with `in_last`=1 has been accepted, no stop has been honoured and `done` is low. At most two entries are ever held.
- R6: A `stop_req` pulse while `busy` is honoured only at the end of a segment whose `in_pkt_end` flag is 1. The rest of the packet plays out first, and entries queued after that segment are discarded without playing.
- R7: After a segment whose `in_last` flag is 1, or after an honoured stop, two carrier periods of low output follow. Then `done` pulses high for one cycle while `busy` is low.
- R8: If a segment ends with no next entry held, and that segment neither ends the stream nor honours a stop, then `underrun` goes high, the line goes low, no trailer plays, and `done` pulses in the very next cycle.
- R9: After `done`, the block is idle and accepts a new start. `underrun` clears when that start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period_m1 | input | PER_W | Carrier period in clock cycles minus one |
| cfg_compare | input | PER_W+1 | Phase at which the mark output turns high |
| start | input | 1 | Start request, sampled while idle |
| stop_req | input | 1 | Stop request pulse, honoured at packet end |
| in_valid | input | 1 | Entry valid |
| in_ready | output | 1 | Entry accepted at this edge if valid |
| in_level | input | 1 | 1 = mark (carrier), 0 = space (low) |
| in_reps_m1 | input | 16 | Segment length in carrier periods minus one |
| in_pkt_end | input | 1 | Entry closes a packet |
| in_last | input | 1 | Entry closes the whole transmission |
| tx_out | output | 1 | Modulated infrared drive |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle completion pulse |
| underrun | output | 1 | Set when the stream ran dry, cleared at next start |

## Verification
The assertions assume that the producer never changes a pending entry while `in_ready` is low. They also assume that the configuration inputs matter only in the cycle a start is sampled, and that `stop_req` is a short pulse. The bench drives every input on the falling clock edge. It offers an entry and holds it until it sees `in_ready` high on a falling edge, and only after that transfer does it move to the next entry. It changes the configuration only together with a start request. Its waveform checks follow from the phase rule and the carrier counts alone, so the bench rebuilds the expected line cycle by cycle from each entry.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  parameter int unsigned IRTX_REP_W = 16;

  typedef struct packed {
    logic                  level;
    logic [IRTX_REP_W-1:0] reps_m1;
    logic                  pkt_end;
    logic                  last;
  } irtx_entry_t;

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_RUN, ST_TRAIL, ST_FIN} irtx_state_e;
endpackage

// File: rtl/irtx_slots.sv
module irtx_slots
  import irtx_pkg::*;
#(
  parameter int unsigned NSLOT = 2,
  localparam int unsigned PW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int unsigned FW = $clog2(NSLOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  irtx_entry_t   push_ent,
  input  logic          pop,
  input  logic          flush,
  output irtx_entry_t   head,
  output logic [FW-1:0] fill
);
  logic [PW-1:0] rd_q, wr_q;
  logic [FW-1:0] fill_q;
  irtx_entry_t   slot_v [NSLOT];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(NSLOT - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    irtx_entry_t ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else if (push && !flush && (wr_q == PW'(g))) ent_q <= push_ent;
    end
    assign slot_v[g] = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0; wr_q <= '0; fill_q <= '0;
    end else if (flush) begin
      rd_q <= '0; wr_q <= '0; fill_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      fill_q <= fill_q + FW'(push) - FW'(pop);
    end
  end

  assign head = slot_v[rd_q];
  assign fill = fill_q;

  // R5: the producer is never allowed to write into a full double buffer
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fill_q < FW'(NSLOT)));
  // R8: a segment never retires from an empty buffer
  assert_no_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fill_q != '0));
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int unsigned PER_W = 16,
  localparam int unsigned CMP_W = PER_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] per_m1,
  input  logic [CMP_W-1:0] cmp,
  input  logic             mark,
  output logic             wrap,
  output logic             pwm
);
  logic [PER_W-1:0] cnt_q;

  assign wrap = run && (cnt_q == per_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || wrap)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + PER_W'(1);
  end

  // Line goes active from the compare phase to the end of the period
  assign pwm = run && mark && ({1'b0, cnt_q} >= cmp);

  // R4: phase never runs past the latched period
  assert_phase_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= per_m1));
endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
  import irtx_pkg::*;
#(
  parameter int unsigned PER_W      = 16,
  parameter int unsigned MIN_PER_M1 = 3124,
  parameter int unsigned MAX_PER_M1 = 12499,
  parameter int unsigned FW         = 2,
  localparam int unsigned CMP_W = PER_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop_req,
  input  logic [PER_W-1:0] cfg_period_m1,
  input  logic [CMP_W-1:0] cfg_compare,
  input  logic             wrap,
  input  irtx_entry_t      head,
  input  logic [FW-1:0]    fill,
  input  logic             push,
  input  logic             push_last,
  output logic             run,
  output logic             mark,
  output logic [PER_W-1:0] per_m1,
  output logic [CMP_W-1:0] cmp,
  output logic             pop,
  output logic             flush,
  output logic             closed,
  output logic             busy,
  output logic             done,
  output logic             underrun
);
  irtx_state_e st_q, st_d;
  logic [IRTX_REP_W-1:0] rep_q;
  logic trail_q, stop_q, closed_q, under_q;
  logic cfg_ok, seg_end, finish_pkt, starved;

  assign cfg_ok = (cfg_period_m1 >= PER_W'(MIN_PER_M1)) &&
                  (cfg_period_m1 <= PER_W'(MAX_PER_M1)) &&
                  (cfg_compare <= ({1'b0, cfg_period_m1} + CMP_W'(1)));
  assign seg_end    = (st_q == ST_RUN) && wrap && (rep_q == head.reps_m1);
  assign finish_pkt = head.last || (head.pkt_end && (stop_q || stop_req));
  assign starved    = ((st_q == ST_PRE) && wrap && (fill == '0)) ||
                      (seg_end && !finish_pkt && (fill < FW'(2)));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start && cfg_ok) st_d = ST_PRE;
      ST_PRE:   if (wrap) st_d = (fill != '0) ? ST_RUN : ST_FIN;
      ST_RUN:   if (seg_end) begin
                  if (finish_pkt)            st_d = ST_TRAIL;
                  else if (fill < FW'(2))    st_d = ST_FIN;
                end
      ST_TRAIL: if (wrap && trail_q) st_d = ST_FIN;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; rep_q <= '0; trail_q <= 1'b0; stop_q <= 1'b0;
      closed_q <= 1'b0; under_q <= 1'b0; per_m1 <= '0; cmp <= '0;
    end else begin
      st_q <= st_d;
      if ((st_q == ST_IDLE) && (st_d == ST_PRE)) begin
        per_m1  <= cfg_period_m1;
        cmp     <= cfg_compare;
        under_q <= 1'b0;
      end
      if ((st_q != ST_RUN) || seg_end) rep_q <= '0;
      else if (wrap)                   rep_q <= rep_q + IRTX_REP_W'(1);
      trail_q <= (st_q == ST_TRAIL) ? (trail_q | wrap) : 1'b0;
      if (flush)                  stop_q <= 1'b0;
      else if (stop_req && busy)  stop_q <= 1'b1;
      if (flush) closed_q <= 1'b0;
      else if ((push && push_last) || (st_d == ST_TRAIL) || starved) closed_q <= 1'b1;
      if (starved) under_q <= 1'b1;
    end
  end

  assign busy     = (st_q == ST_PRE) || (st_q == ST_RUN) || (st_q == ST_TRAIL);
  assign run      = busy;
  assign mark     = (st_q == ST_RUN) && head.level;
  assign pop      = seg_end;
  assign flush    = (st_q == ST_FIN);
  assign done     = flush;
  assign closed   = closed_q;
  assign underrun = under_q;

  // R1: an out-of-range configuration leaves the block idle
  assert_refused_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && start && !cfg_ok) |=> (st_q == ST_IDLE));
  // R4: mark/space changes happen only on a carrier boundary
  assert_level_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mark != $past(mark))) |-> $past(wrap));
  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: a starved stream finishes with no trailer
  assert_underrun_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(under_q) |-> (st_q == ST_FIN));
endmodule

// File: rtl/irtx_modulator.sv
module irtx_modulator
  import irtx_pkg::*;
#(
  parameter int unsigned PER_W      = 16,
  parameter int unsigned MIN_PER_M1 = 3124,
  parameter int unsigned MAX_PER_M1 = 12499,
  localparam int unsigned CMP_W = PER_W + 1,
  localparam int unsigned SLOTS = 2,
  localparam int unsigned FW    = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PER_W-1:0]      cfg_period_m1,
  input  logic [CMP_W-1:0]      cfg_compare,
  input  logic                  start,
  input  logic                  stop_req,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_level,
  input  logic [IRTX_REP_W-1:0] in_reps_m1,
  input  logic                  in_pkt_end,
  input  logic                  in_last,
  output logic                  tx_out,
  output logic                  busy,
  output logic                  done,
  output logic                  underrun
);
  irtx_entry_t      in_ent, head;
  logic [FW-1:0]    fill;
  logic [PER_W-1:0] per_m1;
  logic [CMP_W-1:0] cmp;
  logic run, mark, wrap, pop, flush, closed, push;

  assign in_ent   = '{level: in_level, reps_m1: in_reps_m1, pkt_end: in_pkt_end, last: in_last};
  assign in_ready = (fill < FW'(SLOTS)) && !closed && !done;
  assign push     = in_valid && in_ready;

  irtx_slots #(.NSLOT(SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n), .push(push), .push_ent(in_ent),
    .pop(pop), .flush(flush), .head(head), .fill(fill)
  );

  irtx_seq #(.PER_W(PER_W), .MIN_PER_M1(MIN_PER_M1), .MAX_PER_M1(MAX_PER_M1), .FW(FW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req),
    .cfg_period_m1(cfg_period_m1), .cfg_compare(cfg_compare),
    .wrap(wrap), .head(head), .fill(fill), .push(push), .push_last(in_last),
    .run(run), .mark(mark), .per_m1(per_m1), .cmp(cmp), .pop(pop), .flush(flush),
    .closed(closed), .busy(busy), .done(done), .underrun(underrun)
  );

  irtx_carrier #(.PER_W(PER_W)) u_carrier (
    .clk(clk), .rst_n(rst_n), .run(run), .per_m1(per_m1), .cmp(cmp),
    .mark(mark), .wrap(wrap), .pwm(tx_out)
  );

  // R2: the line is low in the first cycle of a transmission
  assert_quiet_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx_out);
  // R7: outside a transmission the line is never driven high
  assert_low_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_out);
endmodule

// File: tb/test_irtx_modulator.sv
module test_irtx_modulator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_period_m1 = '0;
  logic [4:0]  cfg_compare = '0;
  logic        start = 1'b0, stop_req = 1'b0;
  logic        in_valid = 1'b0, in_level = 1'b0, in_pkt_end = 1'b0, in_last = 1'b0;
  logic [15:0] in_reps_m1 = '0;
  logic        in_ready, tx_out, busy, done, underrun;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 8 ns period

  irtx_modulator #(.PER_W(4), .MIN_PER_M1(2), .MAX_PER_M1(7)) i_irtx_modulator (
    .clk(clk), .rst_n(rst_n), .cfg_period_m1(cfg_period_m1), .cfg_compare(cfg_compare),
    .start(start), .stop_req(stop_req), .in_valid(in_valid), .in_ready(in_ready),
    .in_level(in_level), .in_reps_m1(in_reps_m1), .in_pkt_end(in_pkt_end), .in_last(in_last),
    .tx_out(tx_out), .busy(busy), .done(done), .underrun(underrun)
  );

  // row: {level, reps_m1[2:0], pkt_end, last, expected high cycles[4:0]} for period_m1=3, compare=1
  localparam logic [10:0] TBL [6] = '{
    {1'b1, 3'd2, 1'b0, 1'b0, 5'd9},
    {1'b0, 3'd1, 1'b0, 1'b0, 5'd0},
    {1'b1, 3'd0, 1'b1, 1'b0, 5'd3},
    {1'b1, 3'd3, 1'b0, 1'b0, 5'd12},
    {1'b0, 3'd0, 1'b0, 1'b0, 5'd0},
    {1'b1, 3'd1, 1'b1, 1'b1, 5'd6}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic push_one(input bit l, input int c, input bit pe, input bit la);
    bit taken = 1'b0;
    while (!taken) begin
      @(negedge clk);
      in_valid = 1'b1; in_level = l; in_reps_m1 = 16'(c); in_pkt_end = pe; in_last = la;
      taken = in_ready;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic kick(input int per, input int cmpv);
    @(negedge clk);
    cfg_period_m1 = 4'(per); cfg_compare = 5'(cmpv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // checks the line cycle by cycle from the phase rule; ends on the next segment's first cycle
  task automatic play(input int per, input int cmpv, input bit lvl, input int periods,
                      input string tag, output int hi);
    hi = 0;
    for (int p = 0; p < periods; p++) begin
      for (int ph = 0; ph <= per; ph++) begin
        bit e;
        e = lvl && (ph >= cmpv);
        chk((tx_out === e) && (busy === 1'b1), tag, int'({tx_out, busy}), int'({e, 1'b1}));
        if (tx_out) hi++;
        @(negedge clk);
      end
    end
  endtask

  task automatic trailer_and_done(input int per);
    int h;
    chk(in_ready === 1'b0, "R5 ready closed in trailer", int'(in_ready), 0);
    play(per, 0, 1'b0, 2, "R7 trailer low", h);
    chk((done === 1'b1) && (busy === 1'b0), "R7 done pulse", int'({done, busy}), 2);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int h;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, tx_out, underrun} === 4'b0, "R9 reset idle", int'({busy, done, tx_out, underrun}), 0);
    chk(in_ready === 1'b1, "R5 reset ready", int'(in_ready), 1);

    // R1: three refused configurations
    kick(9, 2); chk(busy === 1'b0, "R1 period too long", int'(busy), 0);
    kick(1, 0); chk(busy === 1'b0, "R1 period too short", int'(busy), 0);
    kick(3, 5); chk(busy === 1'b0, "R1 compare too large", int'(busy), 0);
    @(negedge clk);
    chk(busy === 1'b0, "R1 still idle", int'(busy), 0);

    // vector table walk: P=3, compare=1
    push_one(TBL[0][10], int'(TBL[0][9:7]), TBL[0][6], TBL[0][5]);
    push_one(TBL[1][10], int'(TBL[1][9:7]), TBL[1][6], TBL[1][5]);
    kick(3, 1);
    fork
      for (int k = 2; k < 6; k++) push_one(TBL[k][10], int'(TBL[k][9:7]), TBL[k][6], TBL[k][5]);
      begin
        play(3, 1, 1'b0, 1, "R2 preamble low", h);
        for (int k = 0; k < 6; k++) begin
          play(3, 1, TBL[k][10], int'(TBL[k][9:7]) + 1, "R3 carrier shape", h);
          chk(h == int'(TBL[k][4:0]), "R4 segment length", h, int'(TBL[k][4:0]));
        end
        trailer_and_done(3);
      end
    join

    // R6: stop honoured only at packet end; C is queued but never plays. compare 0 = full mark
    push_one(1'b1, 1, 1'b0, 1'b0);
    push_one(1'b0, 0, 1'b1, 1'b0);
    kick(2, 0);
    fork
      begin stop_req = 1'b1; @(negedge clk); stop_req = 1'b0; end
      push_one(1'b1, 0, 1'b0, 1'b0);
      begin
        play(2, 0, 1'b0, 1, "R2 preamble low", h);
        play(2, 0, 1'b1, 2, "R6 packet plays on", h);
        chk(h == 6, "R3 compare zero full high", h, 6);
        play(2, 0, 1'b0, 1, "R6 space before end", h);
        trailer_and_done(2);
      end
    join

    // R8: one entry only, compare = period+1 gives no high cycle
    push_one(1'b1, 0, 1'b0, 1'b0);
    kick(3, 4);
    play(3, 4, 1'b0, 1, "R2 preamble low", h);
    play(3, 4, 1'b1, 1, "R3 compare max never high", h);
    chk(h == 0, "R3 zero duty", h, 0);
    chk({done, busy, underrun, tx_out} === 4'b1010, "R8 immediate stop",
        int'({done, busy, underrun, tx_out}), 10);
    @(negedge clk);
    chk((underrun === 1'b1) && (busy === 1'b0), "R8 flag held", int'({underrun, busy}), 2);

    // R9: restart after done clears underrun
    push_one(1'b1, 0, 1'b1, 1'b1);
    kick(3, 2);
    chk((busy === 1'b1) && (underrun === 1'b0), "R9 restart accepted", int'({busy, underrun}), 2);
    play(3, 2, 1'b0, 1, "R2 preamble low", h);
    play(3, 2, 1'b1, 1, "R3 half duty", h);
    chk(h == 2, "R3 half duty count", h, 2);
    trailer_and_done(3);

    summary();
  end
endmodule